// File: doc/BRIEF.md
# Hardware Return Address Stack

This block keeps the return addresses of nested subroutine calls in a dedicated last-in-first-out store. A call strobes `push_i` with the address of the instruction after the call, and a return strobes `pop_i` to get that address back on `ret_addr_o`. Entries are 21 bits wide. A 5-bit pointer always names the most recently written slot, not the next free one. Slot 0 is never written, so the store holds at most 31 addresses.

The current top entry is always visible on `tos_o`. The pointer value and the full and empty conditions are also outputs. A push into a full store or a pop from an empty one changes no entry. Either mistake sets a sticky error flag, which stays set until reset. Raising push and pop together replaces the top entry in place. This suits a return that is followed at once by a call.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset, `ptr_o` is 0, `empty_o` is 1, `full_o`, `overflow_o` and `underflow_o` are 0, and `tos_o` and `ret_addr_o` are 0.
- R2: A push alone with the pointer below 31 first adds one to the pointer and then writes `push_addr_i` at the new pointer. The first push after reset therefore fills slot 1.
- R3: A pop alone with the pointer above 0 loads the entry at the current pointer into `ret_addr_o` and then subtracts one from the pointer.
- R4: Addresses come back in the reverse of the order they were pushed.
- R5: Thirty-one pushes from empty bring the pointer to 31, and all 31 addresses are kept.
- R6: A push alone at pointer 31 changes neither the pointer nor any entry. The entry at slot 31 still reads back as the last address that was stored. The push sets `overflow_o`.
- R7: A pop at pointer 0, alone or together with a push, leaves the pointer at 0, loads 0 into `ret_addr_o`, stores nothing and sets `underflow_o`.
- R8: Push and pop together at a nonzero pointer load the old top entry into `ret_addr_o` and overwrite the top entry with `push_addr_i`. The pointer does not change.
- R9: `empty_o` is 1 exactly when the pointer is 0, and `full_o` is 1 exactly when the pointer is 31.
- R10: `overflow_o` and `underflow_o` stay set through later pushes and pops, and only reset clears them.
- R11: `tos_o` shows the entry at the current pointer without delay, and shows 0 while the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| push_addr_i | input | 21 | Return address to store |
| tos_o | output | 21 | Entry at the current pointer (0 when empty) |
| ret_addr_o | output | 21 | Address delivered by the last pop |
| ptr_o | output | 5 | Pointer to the last used slot |
| full_o | output | 1 | Pointer equals 31 |
| empty_o | output | 1 | Pointer equals 0 |
| overflow_o | output | 1 | Sticky: push was attempted while full |
| underflow_o | output | 1 | Sticky: pop was attempted while empty |

## Verification
Every effect of a strobe comes from a register, so it shows on the pointer, the flags, `ret_addr_o` and `tos_o` after the first rising edge that samples the strobe. `full_o`, `empty_o` and `tos_o` are decoded from state that is already registered and add no cycle of their own. The bench sets its strobes at a falling edge and takes them away at the next falling edge. Checks are made at that second falling edge, which is half a period after the only edge that could change the result. The sticky flags are checked again after later, unrelated operations and then after a new reset.

// File: rtl/ras_pkg.sv
package ras_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_PUSH = 2'b01,
      OP_POP  = 2'b10,
      OP_SWAP = 2'b11
   } ras_op_t;

   function automatic ras_op_t ras_decode(input logic push, input logic pop);
      return ras_op_t'({pop, push});
   endfunction

endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
   import ras_pkg::*;
#(
   parameter int PTR_W = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             push_i,
   input  logic             pop_i,
   output logic [PTR_W-1:0] ptr_o,
   output logic             wr_en_o,
   output logic [PTR_W-1:0] wr_slot_o,
   output logic             rd_load_o,
   output logic             ovf_o,
   output logic             unf_o
);
   localparam logic [PTR_W-1:0] TOP_SLOT = {PTR_W{1'b1}};
   localparam logic [PTR_W-1:0] NIL_SLOT = '0;

   logic [PTR_W-1:0] ptr_q, ptr_d;
   logic             set_ovf, set_unf;
   logic             ovf_q, unf_q;
   ras_op_t          op;

   assign op = ras_decode(push_i, pop_i);

   always_comb begin
      ptr_d     = ptr_q;
      wr_en_o   = 1'b0;
      wr_slot_o = ptr_q;
      rd_load_o = 1'b0;
      set_ovf   = 1'b0;
      set_unf   = 1'b0;
      unique case (op)
         OP_PUSH: begin
            if (ptr_q == TOP_SLOT) begin
               set_ovf = 1'b1;
            end else begin
               ptr_d     = ptr_q + 1'b1;
               wr_en_o   = 1'b1;
               wr_slot_o = ptr_q + 1'b1;
            end
         end
         OP_POP: begin
            rd_load_o = 1'b1;
            if (ptr_q == NIL_SLOT) set_unf = 1'b1;
            else                   ptr_d   = ptr_q - 1'b1;
         end
         OP_SWAP: begin
            rd_load_o = 1'b1;
            if (ptr_q == NIL_SLOT) set_unf = 1'b1;
            else                   wr_en_o = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ptr_q <= '0;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else begin
         ptr_q <= ptr_d;
         ovf_q <= ovf_q | set_ovf;
         unf_q <= unf_q | set_unf;
      end
   end

   assign ptr_o = ptr_q;
   assign ovf_o = ovf_q;
   assign unf_o = unf_q;

endmodule

// File: rtl/ras_store.sv
module ras_store #(
   parameter int ADDR_W      = 21,
   parameter int PTR_W       = 5,
   parameter bit STORE_RESET = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [PTR_W-1:0]  wr_slot_i,
   input  logic [ADDR_W-1:0] wr_data_i,
   input  logic [PTR_W-1:0]  rd_slot_i,
   output logic [ADDR_W-1:0] rd_data_o
);
   localparam int DEPTH = 1 << PTR_W;

   logic [ADDR_W-1:0] slot_val [DEPTH];

   // slot 0 holds no storage and always reads as zero
   assign slot_val[0] = '0;

   for (genvar s = 1; s < DEPTH; s++) begin : g_slot
      logic [ADDR_W-1:0] q;
      logic              hit;
      assign hit = wr_en_i && (wr_slot_i == s[PTR_W-1:0]);
      if (STORE_RESET) begin : g_rst
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)  q <= '0;
            else if (hit) q <= wr_data_i;
         end
      end else begin : g_norst
         always_ff @(posedge clk_i) begin
            if (hit) q <= wr_data_i;
         end
      end
      assign slot_val[s] = q;
   end

   assign rd_data_o = slot_val[rd_slot_i];

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
   import ras_pkg::*;
#(
   parameter int ADDR_W      = 21,
   parameter int PTR_W       = 5,
   parameter bit STORE_RESET = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [ADDR_W-1:0] push_addr_i,
   output logic [ADDR_W-1:0] tos_o,
   output logic [ADDR_W-1:0] ret_addr_o,
   output logic [PTR_W-1:0]  ptr_o,
   output logic              full_o,
   output logic              empty_o,
   output logic              overflow_o,
   output logic              underflow_o
);
   localparam logic [PTR_W-1:0] TOP_SLOT = {PTR_W{1'b1}};

   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("ret_addr_stack: ADDR_W must be at least 1");
   end
   if (PTR_W < 2 || PTR_W > 10) begin : g_bad_ptr_w
      $error("ret_addr_stack: PTR_W must lie in 2..10");
   end

   logic              wr_en, rd_load;
   logic [PTR_W-1:0]  wr_slot;
   logic [ADDR_W-1:0] rd_data;
   logic [ADDR_W-1:0] ret_q;

   ras_ptr_ctrl #(.PTR_W(PTR_W)) u_ctrl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .push_i   (push_i),
      .pop_i    (pop_i),
      .ptr_o    (ptr_o),
      .wr_en_o  (wr_en),
      .wr_slot_o(wr_slot),
      .rd_load_o(rd_load),
      .ovf_o    (overflow_o),
      .unf_o    (underflow_o)
   );

   ras_store #(
      .ADDR_W     (ADDR_W),
      .PTR_W      (PTR_W),
      .STORE_RESET(STORE_RESET)
   ) u_store (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en),
      .wr_slot_i(wr_slot),
      .wr_data_i(push_addr_i),
      .rd_slot_i(ptr_o),
      .rd_data_o(rd_data)
   );

   // the old top is read in the same cycle that a swap overwrites it
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ret_q <= '0;
      else if (rd_load) ret_q <= rd_data;
   end

   assign ret_addr_o = ret_q;
   assign tos_o      = rd_data;
   assign full_o     = (ptr_o == TOP_SLOT);
   assign empty_o    = (ptr_o == '0);

endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
   parameter int ADDR_W = 21,
   parameter int PTR_W  = 5
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              push_i,
   input logic              pop_i,
   input logic [ADDR_W-1:0] push_addr_i,
   input logic [ADDR_W-1:0] tos_o,
   input logic [ADDR_W-1:0] ret_addr_o,
   input logic [PTR_W-1:0]  ptr_o,
   input logic              full_o,
   input logic              empty_o,
   input logic              overflow_o,
   input logic              underflow_o
);
   localparam logic [PTR_W-1:0] TOP_SLOT = {PTR_W{1'b1}};

   // R2
   push_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && !pop_i && !full_o) |=>
         (ptr_o == PTR_W'($past(ptr_o) + 1'b1)) && (tos_o == $past(push_addr_i)));

   // R3
   pop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop_i && !push_i && !empty_o) |=>
         (ptr_o == PTR_W'($past(ptr_o) - 1'b1)) && (ret_addr_o == $past(tos_o)));

   // R6
   no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && !pop_i && full_o) |=>
         (ptr_o == TOP_SLOT) && overflow_o && $stable(tos_o));

   // R7
   no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop_i && empty_o) |=> (ptr_o == '0) && underflow_o && (ret_addr_o == '0));

   // R8
   swap_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && pop_i && !empty_o) |=>
         $stable(ptr_o) && (ret_addr_o == $past(tos_o)) && (tos_o == $past(push_addr_i)));

   // R10
   ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      overflow_o |=> overflow_o);

   // R10
   unf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      underflow_o |=> underflow_o);

   // R11
   empty_tos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      empty_o |-> (tos_o == '0));

   // R9
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!push_i && !pop_i) |=> $stable(ptr_o) && $stable(full_o) && $stable(empty_o));

endmodule

bind ret_addr_stack ras_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .push_i     (push_i),
   .pop_i      (pop_i),
   .push_addr_i(push_addr_i),
   .tos_o      (tos_o),
   .ret_addr_o (ret_addr_o),
   .ptr_o      (ptr_o),
   .full_o     (full_o),
   .empty_o    (empty_o),
   .overflow_o (overflow_o),
   .underflow_o(underflow_o)
);

// File: tb/ret_addr_stack_test.sv
`timescale 1ns/1ps
module ret_addr_stack_test;
   localparam int AW = 21;
   localparam int PW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push = 1'b0;
   logic          pop = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [AW-1:0] tos, ret;
   logic [PW-1:0] ptr;
   logic          full, empty, ovf, unf;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   ret_addr_stack uut (
      .clk_i(clk), .rst_ni(rst_n), .push_i(push), .pop_i(pop),
      .push_addr_i(addr), .tos_o(tos), .ret_addr_o(ret), .ptr_o(ptr),
      .full_o(full), .empty_o(empty), .overflow_o(ovf), .underflow_o(unf)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      push = 1'b0; pop = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // one strobe cycle; results are sampled at the falling edge that ends it
   task automatic op(input bit p, input bit q, input logic [AW-1:0] a);
      @(negedge clk);
      push = p; pop = q; addr = a;
      @(negedge clk);
      push = 1'b0; pop = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk(ptr == 0, "R1 ptr", ptr, 0);
      chk(empty && !full, "R1 empty/full", {full, empty}, 1);
      chk(!ovf && !unf, "R1 flags", {ovf, unf}, 0);
      chk(tos == 0 && ret == 0, "R1 tos/ret", tos | ret, 0);
   endtask

   task automatic t_push_pop();
      op(1, 0, 21'h0ABCD);
      chk(ptr == 1, "R2 first push ptr", ptr, 1);
      chk(tos == 21'h0ABCD, "R2 R11 slot1 tos", tos, 21'h0ABCD);
      chk(!empty, "R9 not empty", empty, 0);
      op(1, 0, 21'h1F00E);
      chk(ptr == 2 && tos == 21'h1F00E, "R2 second push", tos, 21'h1F00E);
      op(0, 1, '0);
      chk(ret == 21'h1F00E, "R3 pop data", ret, 21'h1F00E);
      chk(ptr == 1 && tos == 21'h0ABCD, "R3 ptr dec", ptr, 1);
      op(0, 1, '0);
      chk(ret == 21'h0ABCD && ptr == 0, "R3 second pop", ret, 21'h0ABCD);
      chk(tos == 0 && empty, "R11 R9 tos zero when empty", tos, 0);
   endtask

   task automatic t_lifo();
      for (int i = 0; i < 5; i++) op(1, 0, AW'(21'h02000 + i * 7));
      for (int i = 4; i >= 0; i--) begin
         op(0, 1, '0);
         chk(ret == AW'(21'h02000 + i * 7), "R4 reverse order", ret, 21'h02000 + i * 7);
      end
      chk(ptr == 0, "R4 back to empty", ptr, 0);
   endtask

   task automatic t_fill_overflow();
      for (int i = 1; i <= 31; i++) op(1, 0, AW'(21'h10000 + i));
      chk(ptr == 31, "R5 ptr at 31", ptr, 31);
      chk(full && !empty, "R9 full", full, 1);
      chk(!ovf, "R5 no overflow yet", ovf, 0);
      op(1, 0, 21'h1EEEE);
      chk(ptr == 31, "R6 ptr held", ptr, 31);
      chk(ovf == 1'b1, "R6 overflow set", ovf, 1);
      chk(tos == 21'h1001F, "R6 top not overwritten", tos, 21'h1001F);
      for (int i = 31; i >= 1; i--) begin
         op(0, 1, '0);
         chk(ret == AW'(21'h10000 + i), "R5 R4 stored entry", ret, 21'h10000 + i);
      end
      chk(empty && ovf, "R10 overflow sticky after pops", ovf, 1);
   endtask

   task automatic t_swap();
      op(1, 0, 21'h00111);
      op(1, 0, 21'h00222);
      op(1, 1, 21'h00333);
      chk(ptr == 2, "R8 ptr unchanged", ptr, 2);
      chk(ret == 21'h00222, "R8 old top returned", ret, 21'h00222);
      chk(tos == 21'h00333, "R8 top replaced", tos, 21'h00333);
      op(0, 1, '0);
      chk(ret == 21'h00333, "R8 pop replaced", ret, 21'h00333);
      op(0, 1, '0);
      chk(ret == 21'h00111 && ptr == 0, "R8 lower entry intact", ret, 21'h00111);
   endtask

   task automatic t_underflow();
      do_reset();
      op(1, 0, 21'h05555);
      op(0, 1, '0);
      op(0, 1, '0);
      chk(ptr == 0, "R7 ptr stays 0", ptr, 0);
      chk(ret == 0, "R7 returns zero", ret, 0);
      chk(unf == 1'b1 && ovf == 1'b0, "R7 underflow set", unf, 1);
      op(1, 1, 21'h07777);
      chk(ptr == 0 && tos == 0, "R7 swap at empty stores nothing", tos, 0);
      op(1, 0, 21'h01234);
      op(0, 1, '0);
      chk(unf == 1'b1, "R10 underflow sticky", unf, 1);
      chk(ret == 21'h01234, "R2 push after underflow", ret, 21'h01234);
      do_reset();
      chk(!unf && !ovf, "R10 reset clears flags", {ovf, unf}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_push_pop();
      t_lifo();
      t_fill_overflow();
      t_swap();
      t_underflow();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule